// File: doc/BRIEF.md
# Sparse Multiplexer Routing Fabric

This block carries signals from a wide set of global sources (device pins and register feedbacks) to the inputs of one programmable logic block. It does not use a full crosspoint. Each output is driven by its own narrow multiplexer, and that multiplexer can pick only from a small fixed set of candidate sources. Output `j` can reach source `(j*STRIDE + k*OFFSET) mod N_IN` through candidate slot `k`, for `k` from 0 to `W-1`. Every route is one multiplexer deep. When `W` equals the number of sources in a group, the pattern reaches every source of that group, as a full crosspoint would.

Each multiplexer has its own select code. Select codes are loaded through a serial configuration chain while `cfg_en` is high. They are moved into the live select registers only when the load is finished, so the routes in use stay fixed during a reload. A select code that names no candidate slot forces its output to 0. This keeps unused outputs at a defined value.

Top module: `sparse_route_fabric`

## Requirements
- R1: Routing is purely combinational. A change on `data_in` appears on `route_out` in the same cycle, with no clock edge needed.
- R2: When the live select code of output `j` is a value `k` below `W`, `route_out[j]` equals `data_in[(j*STRIDE + k*OFFSET) mod N_IN]`. The defaults are N_IN=32, N_OUT=16, W=2, STRIDE=2 and OFFSET=1.
- R3: A live select code of `W` or more forces its output to 0, whatever `data_in` holds. The all-ones code is one such code. The default select width is `ceil(log2(W+1))` = 2 bits, so codes 2 and 3 are unused codes.
- R4: A clock edge with `rst_n` low sets every live select code and every chain bit to all-ones. After reset, every output is 0.
- R5: The chain is `N_OUT*SW` bits long and shifts by one bit per clock edge with `cfg_en` high. The first bit shifted in ends up as the most significant bit of the field for output `N_OUT-1`. Fields follow in descending output order, each sent MSB first.
- R6: While `cfg_en` is high, the live select codes do not change. Outputs keep following the previous configuration.
- R7: At the first clock edge where `cfg_en` is low after being high, the chain contents become the live select codes. The new routes appear on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and the live select registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain. Its falling edge commits the chain. |
| cfg_din | input | 1 | Serial configuration bit |
| data_in | input | N_IN | Global source signals to be routed |
| route_out | output | N_OUT | Routed signals going to the logic block |

## Verification
`route_out` follows `data_in` with zero latency. The bench changes `data_in` in the middle of the low clock phase and samples 1 ns later, before any clock edge. A new configuration takes effect at the clock edge after `cfg_en` is dropped. The bench drops `cfg_en` on a falling clock edge and checks the routes at the next falling edge, after exactly one rising edge. The requirement that routes hold during a reload is checked in the middle of a shift sequence, against the expected values for the previous configuration.

// File: rtl/fabric_pkg.sv
// Package: shared helpers for the sparse routing fabric.
// Assumes all arguments are non-negative and n_in > 0.
package fabric_pkg;

    // Source index reached by output j through candidate slot k.
    function automatic int src_index(input int j, input int k,
                                     input int stride, input int offset,
                                     input int n_in);
        return (j * stride + k * offset) % n_in;
    endfunction

endpackage

// File: rtl/cfg_chain.sv
// Module: cfg_chain
// Serial configuration shift chain with a separate live register for the
// select codes. Bits shift in at the LSB while cfg_en is high. The chain is
// copied to the live register on the first edge where cfg_en is low after
// being high. Assumes N_OUT*SW >= 2.
module cfg_chain #(
    parameter int N_OUT = 16,
    parameter int SW    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_en,
    input  logic                   cfg_din,
    output logic [N_OUT*SW-1:0]    live_sel
);
    localparam int LEN = N_OUT * SW;

    logic [LEN-1:0] shift_q;
    logic           en_q;

    // Shift register: take one bit per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_q <= '1;
        else if (cfg_en)
            shift_q <= {shift_q[LEN-2:0], cfg_din};
    end

    // Delayed enable, used to find the end of a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= cfg_en;
    end

    // Live selects: commit the chain when the load ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_sel <= '1;
        else if (en_q && !cfg_en)
            live_sel <= shift_q;
    end

    // R4: reset leaves every select at the all-ones code
    p_reset_ones_r4: assert property (@(posedge clk)
        !rst_n |=> (&live_sel));

    // R5: each enabled cycle takes the serial bit into the chain
    p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (shift_q[0] == $past(cfg_din)));

    // R6: the live selects hold while the chain is loading
    p_hold_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> $stable(live_sel));

    // R7: the end of a load copies the chain to the live selects
    p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_en) |=> (live_sel == $past(shift_q)));

endmodule

// File: rtl/route_mux.sv
// Module: route_mux
// One narrow routing multiplexer. It selects one of W fixed candidates from
// data_in, or drives 0 for any code of W or above. Purely combinational.
module route_mux #(
    parameter int N_IN   = 32,
    parameter int W      = 2,
    parameter int SW     = 2,
    parameter int STRIDE = 2,
    parameter int OFFSET = 1,
    parameter int J      = 0
) (
    input  logic [N_IN-1:0] data_in,
    input  logic [SW-1:0]   sel,
    output logic            y
);
    logic [W-1:0] cand;

    // Fixed candidate wiring for this output.
    for (genvar k = 0; k < W; k++) begin : g_cand
        localparam int SRC = fabric_pkg::src_index(J, k, STRIDE, OFFSET, N_IN);
        assign cand[k] = data_in[SRC];
    end

    // One-level select; unused codes give 0.
    always_comb begin
        y = 1'b0;
        for (int k = 0; k < W; k++)
            if (int'(sel) == k) y = cand[k];
    end

endmodule

// File: rtl/sparse_route_fabric.sv
// Module: sparse_route_fabric (top)
// Sparse multiplexer routing fabric. The configuration chain holds the live
// select codes. One route_mux per output maps data_in to route_out.
// Assumes W >= 1 and N_OUT*SW >= 2.
module sparse_route_fabric #(
    parameter int N_IN   = 32,
    parameter int N_OUT  = 16,
    parameter int W      = 2,
    parameter int STRIDE = 2,
    parameter int OFFSET = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic [N_IN-1:0]   data_in,
    output logic [N_OUT-1:0]  route_out
);
    localparam int SW  = $clog2(W + 1);
    localparam int LEN = N_OUT * SW;

    logic [LEN-1:0] live_sel;

    cfg_chain #(.N_OUT(N_OUT), .SW(SW)) chain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .live_sel (live_sel)
    );

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [SW-1:0] sel_j;
        assign sel_j = live_sel[j*SW +: SW];

        route_mux #(
            .N_IN(N_IN), .W(W), .SW(SW),
            .STRIDE(STRIDE), .OFFSET(OFFSET), .J(j)
        ) mux_i (
            .data_in (data_in),
            .sel     (sel_j),
            .y       (route_out[j])
        );

        // R3: codes past the last candidate force the output to 0
        p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(sel_j) >= W) |-> (route_out[j] == 1'b0));

        for (genvar k = 0; k < W; k++) begin : g_chk
            localparam int SRC = fabric_pkg::src_index(j, k, STRIDE, OFFSET, N_IN);
            // R2: a valid code routes its fixed source
            p_route_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(sel_j) == k) |-> (route_out[j] == data_in[SRC]));
        end
    end

endmodule

// File: tb/sparse_route_fabric_tb.sv
// Bench for sparse_route_fabric: pattern table walked over several
// configurations, then directed tests for reset, load order and reload hold.
module sparse_route_fabric_tb_top;
    localparam int N_IN   = 32;
    localparam int N_OUT  = 16;
    localparam int W      = 2;
    localparam int STRIDE = 2;
    localparam int OFFSET = 1;
    localparam int SW     = 2;
    localparam int NPAT   = 8;

    localparam logic [N_IN-1:0] PATS [NPAT] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h5555_5555,
        32'h1234_5678, 32'hDEAD_BEEF, 32'h8000_0001, 32'h0F0F_C3C3
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_en = 1'b0;
    logic              cfg_din = 1'b0;
    logic [N_IN-1:0]   data_in = '0;
    logic [N_OUT-1:0]  route_out;

    int checks = 0;
    int fails  = 0;

    logic [SW-1:0] cur_codes [N_OUT];
    logic [SW-1:0] new_codes [N_OUT];

    always #10 clk = ~clk;

    sparse_route_fabric #(
        .N_IN(N_IN), .N_OUT(N_OUT), .W(W), .STRIDE(STRIDE), .OFFSET(OFFSET)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .data_in(data_in), .route_out(route_out)
    );

    function automatic logic [N_OUT-1:0] model(input logic [N_IN-1:0] d);
        logic [N_OUT-1:0] r = '0;
        for (int j = 0; j < N_OUT; j++)
            if (int'(cur_codes[j]) < W)
                r[j] = d[(j*STRIDE + int'(cur_codes[j])*OFFSET) % N_IN];
        return r;
    endfunction

    task automatic check(input string req, input logic [N_OUT-1:0] act,
                         input logic [N_OUT-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Shift new_codes in (highest output first, MSB first). Optionally check
    // the old routes in the middle of the load. Commit and make new_codes current.
    task automatic load_cfg(input bit mid_check);
        int n = 0;
        for (int j = N_OUT-1; j >= 0; j--) begin
            for (int b = SW-1; b >= 0; b--) begin
                cfg_en  = 1'b1;
                cfg_din = new_codes[j][b];
                @(negedge clk);
                n++;
                if (mid_check && n == N_OUT*SW/2) begin
                    #1 check("R6", route_out, model(data_in));
                end
            end
        end
        cfg_en = 1'b0;
        @(negedge clk);
        for (int j = 0; j < N_OUT; j++) cur_codes[j] = new_codes[j];
    endtask

    task automatic walk_patterns(input string req);
        for (int i = 0; i < NPAT; i++) begin
            data_in = PATS[i];
            #1 check(req, route_out, model(data_in));
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int j = 0; j < N_OUT; j++) cur_codes[j] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: reset leaves every output at 0 even with all sources high
        data_in = '1;
        #1 check("R4", route_out, '0);

        // R2/R3/R1: uniform codes 0..3 over the pattern table
        for (int c = 0; c < (1 << SW); c++) begin
            for (int j = 0; j < N_OUT; j++) new_codes[j] = SW'(c);
            load_cfg(1'b0);
            walk_patterns(c < W ? "R2" : "R3");
        end

        // R5: only the highest output enabled, proving the load order
        for (int j = 0; j < N_OUT; j++) new_codes[j] = '1;
        new_codes[N_OUT-1] = '0;
        load_cfg(1'b0);
        data_in = '0;
        data_in[(N_OUT-1)*STRIDE % N_IN] = 1'b1;
        #1 check("R5", route_out, {1'b1, {(N_OUT-1){1'b0}}});

        // R6/R7: mixed codes loaded with a check in the middle, then verified
        for (int j = 0; j < N_OUT; j++) new_codes[j] = SW'(j % 4);
        data_in = 32'hCAFE_F00D;
        load_cfg(1'b1);
        #1 check("R7", route_out, model(data_in));
        walk_patterns("R2");

        // R1: data changes with no clock edge in between
        @(negedge clk);
        data_in = 32'h0000_FFFF;
        #1 check("R1", route_out, model(data_in));
        data_in = 32'hFFFF_0000;
        #1 check("R1", route_out, model(data_in));

        // R4: a reset after configuration clears all routes
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < N_OUT; j++) cur_codes[j] = '1;
        data_in = '1;
        #1 check("R4", route_out, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule